// File: doc/BRIEF.md
# Serial Status Flag Register

This block holds the eight status bits of a UART-style serial port and sits between the CPU bus and the transmit and receive engines. The engines raise one-cycle set pulses when the transmit holding register empties, a character arrives, an overrun occurs, a stop bit is missing or parity is wrong. They also drive live levels for end-of-transmission and for the multiprocessor bit of the last received frame. The CPU reads the register at any time. It can only clear the sticky flags, and only through a two-step handshake: it first reads a flag as 1, then writes 0 to it.

Each clearable flag has its own arm bit. A CPU read copies the flag's current value into its arm bit. The next CPU write uses the arm bits and then disarms all of them. A transfer agent that refills the transmit data register clears the transmit-empty flag directly, with no read needed. While the transmitter is disabled, the transmit-empty flag is held at 1. An asynchronous reset or a synchronous standby request returns the register to its initial value. Bit 0 is a plain CPU bit that holds the multiprocessor bit to transmit.

Top module: `ser_status_reg`

## Requirements
- R1: After rst_ni is low, or one cycle after standby_i is high, rdata_o reads 0x84 and every arm bit is cleared.
- R2: rdata_o bit positions are: 7 tx-empty, 6 rx-full, 5 overrun, 4 framing error, 3 parity error, 2 tx-done, 1 rx multiprocessor bit, 0 tx multiprocessor bit.
- R3: A one-cycle set pulse on one of the five sticky flags makes that flag read 1 from the next cycle, and it stays 1 until it is cleared.
- R4: A CPU write of 1 to any sticky flag bit (7..3) leaves that flag unchanged.
- R5: A CPU write with 0 in a sticky flag's bit clears that flag only if a CPU read in an earlier cycle, since the last write, returned that flag as 1. Every write disarms all flags. A read in the same cycle as a write does not arm anything.
- R6: When a set pulse and a valid clear hit the same flag in the same cycle, the flag reads 1 afterwards.
- R7: Bits 2 and 1 show tx_end_i and rx_mpb_i delayed by one cycle, and CPU writes do not change them.
- R8: Bit 0 takes cpu_wdata_i[0] on every CPU write and otherwise holds its value. It resets to 0.
- R9: While tx_en_i is 0, bit 7 reads 1 from the next cycle, whatever clears are applied.
- R10: agent_tdr_wr_i clears bit 7 with no earlier read, unless a set or the disabled transmitter holds it in the same cycle. It does not change the arm bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Synchronous return to the initial state |
| tx_en_i | input | 1 | Transmitter enable level |
| cpu_rd_i | input | 1 | CPU read strobe (arms the flags that read 1) |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | Register contents |
| set_tx_empty_i | input | 1 | Pulse: transmit data moved to the shifter |
| set_rx_full_i | input | 1 | Pulse: received character ready |
| set_overrun_i | input | 1 | Pulse: overrun detected |
| set_frame_err_i | input | 1 | Pulse: framing error detected |
| set_parity_err_i | input | 1 | Pulse: parity error detected |
| tx_end_i | input | 1 | Live transmit-complete level |
| rx_mpb_i | input | 1 | Live received multiprocessor bit |
| agent_tdr_wr_i | input | 1 | Transfer agent wrote the transmit data register |

## Verification
If an arm bit holds the wrong value, the CPU-visible effect is a write of 0 that clears a flag it should keep, or keeps a flag it should clear. This shows on rdata_o one cycle after the write. It can stay hidden until a read followed by a write exercises that flag. For this reason the stimulus mixes reads and writes densely, and it includes directed cases where a flag is set between the arming read and the clearing write. A lost set pulse or a wrong priority between set and clear shows on rdata_o in the very next cycle.

// File: rtl/ser_status_pkg.sv
package ser_status_pkg;
  localparam int REG_W       = 8;
  localparam int NUM_STICKY  = 5;
  localparam int STICKY_LSB  = REG_W - NUM_STICKY;
  localparam int TXE_IDX     = NUM_STICKY - 1;   // tx-empty within sticky vector
  localparam int TEND_BIT    = 2;
  localparam int RMPB_BIT    = 1;
  localparam int TMPB_BIT    = 0;
  localparam logic [REG_W-1:0] INIT_VAL = 8'h84;
endpackage

// File: rtl/sticky_flag.sv
module sticky_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic set_i,
  input  logic clr_now_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, arm_q;
  logic cpu_clr;

  assign cpu_clr = wr_i && !wbit_i && arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else if (init_i) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)                   flag_q <= 1'b1;  // set beats any clear
      else if (clr_now_i || cpu_clr) flag_q <= 1'b0;
      if (wr_i)      arm_q <= 1'b0;
      else if (rd_i) arm_q <= flag_q;
    end
  end

  assign flag_o = flag_q;

  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !init_i) |=> flag_o);
  a_r4_no_cpu_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set_i || init_i));
  a_r5_clear_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(init_i || clr_now_i || (wr_i && !wbit_i && arm_q)));
  a_r5_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !arm_q);
endmodule

// File: rtl/status_bit.sv
module status_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic load_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= RST_VAL;
    else if (init_i) q_o <= RST_VAL;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/ser_status_reg.sv
module ser_status_reg
  import ser_status_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             standby_i,
  input  logic             tx_en_i,
  input  logic             cpu_rd_i,
  input  logic             cpu_wr_i,
  input  logic [REG_W-1:0] cpu_wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             set_tx_empty_i,
  input  logic             set_rx_full_i,
  input  logic             set_overrun_i,
  input  logic             set_frame_err_i,
  input  logic             set_parity_err_i,
  input  logic             tx_end_i,
  input  logic             rx_mpb_i,
  input  logic             agent_tdr_wr_i
);
  logic [NUM_STICKY-1:0] hw_set, set_eff, clr_now, flags;
  logic tend_q, rmpb_q, tmpb_q;
  logic unused_wbits;

  assign hw_set = {set_tx_empty_i, set_rx_full_i, set_overrun_i,
                   set_frame_err_i, set_parity_err_i};
  assign unused_wbits = ^cpu_wdata_i[TEND_BIT:RMPB_BIT];

  for (genvar k = 0; k < NUM_STICKY; k++) begin : g_flag
    localparam logic RV = INIT_VAL[STICKY_LSB + k];
    if (k == TXE_IDX) begin : g_txe
      assign set_eff[k] = hw_set[k] || !tx_en_i;
      assign clr_now[k] = agent_tdr_wr_i;
    end else begin : g_plain
      assign set_eff[k] = hw_set[k];
      assign clr_now[k] = 1'b0;
    end
    sticky_flag #(.RST_VAL(RV)) i_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .init_i   (standby_i),
      .set_i    (set_eff[k]),
      .clr_now_i(clr_now[k]),
      .rd_i     (cpu_rd_i),
      .wr_i     (cpu_wr_i),
      .wbit_i   (cpu_wdata_i[STICKY_LSB + k]),
      .flag_o   (flags[k])
    );
  end

  status_bit #(.RST_VAL(INIT_VAL[TEND_BIT])) i_tend (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(standby_i),
    .load_i(1'b1), .d_i(tx_end_i), .q_o(tend_q));
  status_bit #(.RST_VAL(INIT_VAL[RMPB_BIT])) i_rmpb (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(standby_i),
    .load_i(1'b1), .d_i(rx_mpb_i), .q_o(rmpb_q));
  status_bit #(.RST_VAL(INIT_VAL[TMPB_BIT])) i_tmpb (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(standby_i),
    .load_i(cpu_wr_i), .d_i(cpu_wdata_i[TMPB_BIT]), .q_o(tmpb_q));

  assign rdata_o = {flags, tend_q, rmpb_q, tmpb_q};

  a_r1_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (rdata_o == INIT_VAL));
  a_r9_txe_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> rdata_o[REG_W-1]);
  a_r7_tend_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !standby_i |=> (rdata_o[TEND_BIT] == $past(tx_end_i)));
  a_r8_tmpb_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && !standby_i) |=> (rdata_o[TMPB_BIT] == $past(cpu_wdata_i[TMPB_BIT])));
endmodule

// File: tb/test_ser_status_reg.sv
module test_ser_status_reg;
  localparam time CLK_P = 4ns;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic standby = 0, tx_en = 1, rd = 0, wr = 0, agent = 0;
  logic [7:0] wdata = 0, rdata;
  logic [4:0] hs = 0;  // {txe, rxf, ovr, frm, par}
  logic tx_end = 1, rx_mpb = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [4:0] m_flag, m_arm;
  logic m_tend, m_mpb, m_mpbt;

  always #(CLK_P/2) clk = ~clk;

  ser_status_reg i_ser_status_reg (
    .clk_i(clk), .rst_ni(rst_ni), .standby_i(standby), .tx_en_i(tx_en),
    .cpu_rd_i(rd), .cpu_wr_i(wr), .cpu_wdata_i(wdata), .rdata_o(rdata),
    .set_tx_empty_i(hs[4]), .set_rx_full_i(hs[3]), .set_overrun_i(hs[2]),
    .set_frame_err_i(hs[1]), .set_parity_err_i(hs[0]),
    .tx_end_i(tx_end), .rx_mpb_i(rx_mpb), .agent_tdr_wr_i(agent));

  function automatic logic [7:0] expected();
    return {m_flag, m_tend, m_mpb, m_mpbt};
  endfunction

  task automatic model_init();
    m_flag = 5'b10000; m_arm = 0; m_tend = 1; m_mpb = 0; m_mpbt = 0;
  endtask

  // next state from requirements R1, R3..R10
  task automatic model_step();
    logic [4:0] nf, na;
    if (standby) begin model_init(); return; end
    for (int k = 0; k < 5; k++) begin
      logic s, c;
      s = hs[k] || (k == 4 && !tx_en);
      c = (wr && !wdata[k+3] && m_arm[k]) || (k == 4 && agent);
      nf[k] = s ? 1'b1 : (c ? 1'b0 : m_flag[k]);
      na[k] = wr ? 1'b0 : (rd ? m_flag[k] : m_arm[k]);
    end
    m_flag = nf; m_arm = na;
    m_tend = tx_end; m_mpb = rx_mpb;
    if (wr) m_mpbt = wdata[0];
  endtask

  task automatic check(string tag);
    checks++;
    if (rdata !== expected()) begin
      errors++;
      $display("FAIL %s: rdata=%02h expected=%02h", tag, rdata, expected());
    end
  endtask

  // inputs are set at a negedge; one edge later the result is checked
  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag);
    standby = 0; rd = 0; wr = 0; agent = 0; hs = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_init();
    repeat (3) @(negedge clk);
    check("R1 reset");                    // 0x84
    rst_ni = 1;
    @(negedge clk);
    check("R1 after release");

    hs[3] = 1;        tick("R2 R3 rx-full at bit 6");      // C4
    wdata = 8'h00; wr = 1; tick("R5 write0 unarmed");      // C4
    wdata = 8'hFF; wr = 1; tick("R4 R8 write ones");       // C5
    rd = 1;           tick("R5 arming read");
    wdata = 8'h01; wr = 1; tick("R5 armed clear");         // 05
    hs[4] = 1;        tick("R3 tx-empty set");             // 85
    agent = 1;        tick("R10 agent clear");             // 05
    tx_en = 0;        tick("R9 disabled holds");           // 85
    agent = 1;        tick("R9 agent vs held");            // 85
    tx_en = 1; rd = 1; tick("R9 re-enable");
    wdata = 8'h01; wr = 1; tick("R5 clear tx-empty");      // 05
    hs[2] = 1;        tick("R3 overrun");                  // 25
    rd = 1;           tick("R5 arm overrun");
    wdata = 8'h01; wr = 1; hs[2] = 1; tick("R6 set wins"); // 25
    rd = 1; wr = 1; wdata = 8'h01; tick("R5 read with write no arm");
    wdata = 8'h01; wr = 1; tick("R5 still set");           // 25
    rd = 1;           tick("R5 arm before parity");
    hs[0] = 1;        tick("R3 parity after arm");         // 2D
    wdata = 8'h01; wr = 1; tick("R5 only armed cleared");  // 0D
    tx_end = 0; rx_mpb = 1; tick("R7 levels follow");      // 0B
    wdata = 8'h06; wr = 1; tick("R7 write ignored");       // 0A
    standby = 1;      tick("R1 standby");                  // 84

    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4000; i++) begin
      tx_en   = ($urandom % 10) != 0;
      standby = ($urandom % 60) == 0;
      rd      = ($urandom % 3) == 0;
      wr      = ($urandom % 4) == 0;
      agent   = ($urandom % 8) == 0;
      wdata   = 8'($urandom);
      tx_end  = 1'($urandom);
      rx_mpb  = 1'($urandom);
      for (int k = 0; k < 5; k++) hs[k] = ($urandom % 6) == 0;
      tick("R5 R6 random mix");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule